// File: doc/BRIEF.md
# Dual-Clock FIFO Controller with Look-Ahead Read

A FIFO that buffers fixed-width words between a producer and a consumer. It can run from two unrelated clocks, or from one clock shared by both sides. The block keeps its own write and read addresses. It reports four status flags: full, empty, almost-full and almost-empty. The two "almost" levels come from run-time threshold inputs. The stored word width is the same on both sides.

When the clocks are unrelated, each side's pointer crosses to the other side as Gray code through a synchroniser chain. Each pointer carries one extra bit so that a full FIFO can be told apart from an empty one. Full and almost-full are decoded on the write side, and empty and almost-empty on the read side. Each flag therefore lags the far side's activity and errs toward the safe state.

A parameter chooses the read style:
- In standard mode, a read request returns its word one read-clock later.
- In look-ahead mode, the oldest word already sits on the read data output, and a read request consumes it.

A write while full and a read while empty are dropped. Each drop sets a sticky error flag that stays set until reset.

Top module: `dc_fifo`

## Requirements
- R1: After reset, empty_o and aempty_o are 1; full_o, afull_o (threshold above zero), wover_o and runder_o are 0.
- R2: Every accepted word is read out exactly once and in write order, with either independent clocks or one shared clock.
- R3: A write while full_o is 1 stores nothing. It sets wover_o, which stays 1 until reset.
- R4: A read while empty_o is 1 consumes nothing. It sets runder_o, which stays 1 until reset.
- R5: Once both sides have settled, full_o is 1 exactly when DEPTH (2**ADDR_W) words are held.
- R6: Once settled, empty_o is 1 exactly when no word is held.
- R7: Once settled, afull_o is 1 exactly when the held count is greater than or equal to afull_thr_i.
- R8: Once settled, aempty_o is 1 exactly when the held count is less than or equal to aempty_thr_i.
- R9: In standard mode, a read accepted at a read-clock edge shows its word on rdata_o after that edge. rdata_o holds while no read is accepted.
- R10: In look-ahead mode, the first word written appears on rdata_o with empty_o at 0 before any read is requested. With one shared clock, this happens one clock after the write edge.
- R11: In look-ahead mode, rdata_o always shows the oldest unread word while empty_o is 0. A read consumes that word. The word held in the output register still counts as held for the full, almost-full and almost-empty flags.
- R12: A write and a read in the same cycle both take effect, leaving the held count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset for both sides |
| wclk_i | input | 1 | Write clock |
| wen_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Write data |
| afull_thr_i | input | ADDR_W+1 | Almost-full level |
| full_o | output | 1 | FIFO full (write side) |
| afull_o | output | 1 | Held count at or above afull_thr_i |
| wover_o | output | 1 | Sticky: write attempted while full |
| rclk_i | input | 1 | Read clock (tie to wclk_i when ASYNC=0) |
| ren_i | input | 1 | Read request |
| aempty_thr_i | input | ADDR_W+1 | Almost-empty level |
| rdata_o | output | DATA_W | Read data |
| empty_o | output | 1 | No word available to read |
| aempty_o | output | 1 | Held count at or below aempty_thr_i |
| runder_o | output | 1 | Sticky: read attempted while empty |

## Verification
A write and a read can fall in the same cycle. In look-ahead mode on a shared clock, a read can also coincide with reloading the output register from storage.

The bench drives a single-clock look-ahead instance with random write and read requests, so that many cycles carry both at once, including cycles at the almost-full and almost-empty levels and at full. On every cycle it compares rdata_o with the head of a reference queue, and full_o, afull_o and aempty_o with the queue's size.

The dual-clock instance runs both sides concurrently at unrelated periods, with the data order checked word by word. Its flags are judged only after both synchroniser chains have settled.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read is unclocked; an entry is only addressed after its pointer has crossed
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_ptr_xing.sv
module dcf_ptr_xing #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_s;

  if (STAGES == 0) begin : g_direct
    assign gray_s = gray_i;
  end else begin : g_sync
    logic [W-1:0] sr_q [STAGES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < STAGES; i++) sr_q[i] <= '0;
      end else begin
        sr_q[0] <= gray_i;
        for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
      end
    end
    assign gray_s = sr_q[STAGES-1];
  end

  always_comb begin
    logic [W-1:0] b;
    b[W-1] = gray_s[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ gray_s[i];
    bin_o = b;
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W:0]   thr_i,
  input  logic [ADDR_W:0]   rptr_i,
  output logic              full_o,
  output logic              afull_o,
  output logic              over_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W:0]   gray_o
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1 << ADDR_W);

  logic [CNT_W-1:0] wptr_q, wptr_nxt, wcnt;
  logic [CNT_W-1:0] gray_q;
  logic             over_q, push;

  assign wcnt    = wptr_q - rptr_i;
  assign full_o  = (wcnt == DEPTH);
  assign afull_o = (wcnt >= thr_i);
  assign push    = wen_i && !full_o;
  assign wptr_nxt = wptr_q + CNT_W'(push);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      gray_q <= '0;
      over_q <= 1'b0;
    end else begin
      wptr_q <= wptr_nxt;
      gray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      if (wen_i && full_o) over_q <= 1'b1;
    end
  end

  assign over_o      = over_q;
  assign gray_o      = gray_q;
  assign mem_we_o    = push;
  assign mem_waddr_o = wptr_q[ADDR_W-1:0];
  assign mem_wdata_o = wdata_i;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i && full_o) |=> $stable(wptr_q));
  p_over_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |=> over_o);
  p_level_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt <= DEPTH);
  p_full_afull_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && thr_i <= DEPTH) |-> afull_o);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int                  ADDR_W  = 4,
  parameter int                  DATA_W  = 8,
  parameter dcf_pkg::rd_mode_e   RD_MODE = dcf_pkg::RD_STD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_i,
  input  logic [ADDR_W:0]   thr_i,
  input  logic [ADDR_W:0]   wptr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              under_o,
  output logic [ADDR_W:0]   gray_o
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1 << ADDR_W);

  // cptr counts words handed to the consumer; it is what the write side sees
  logic [CNT_W-1:0] cptr_q, cptr_nxt, level;
  logic [CNT_W-1:0] gray_q;
  logic             under_q, take;
  logic [DATA_W-1:0] data_q;

  assign level    = wptr_i - cptr_q;
  assign aempty_o = (level <= thr_i);
  assign cptr_nxt = cptr_q + CNT_W'(take);

  if (RD_MODE == dcf_pkg::RD_FWFT) begin : g_fwft
    logic [CNT_W-1:0] rptr_q;
    logic             valid_q, ram_has, load;

    assign ram_has     = (wptr_i != rptr_q);
    assign take        = ren_i && valid_q;
    assign load        = ram_has && (!valid_q || take);
    assign empty_o     = !valid_q;
    assign mem_raddr_o = rptr_q[ADDR_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rptr_q  <= '0;
        valid_q <= 1'b0;
        data_q  <= '0;
      end else if (load) begin
        data_q  <= mem_rdata_i;
        rptr_q  <= rptr_q + 1'b1;
        valid_q <= 1'b1;
      end else if (take) begin
        valid_q <= 1'b0;
      end
    end

    p_fwft_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!empty_o && !ren_i) |=> (!empty_o && $stable(rdata_o)));
    p_fwft_out_in_level_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !empty_o |-> (level != '0));
  end else begin : g_std
    assign empty_o     = (level == '0);
    assign take        = ren_i && !empty_o;
    assign mem_raddr_o = cptr_q[ADDR_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   data_q <= '0;
      else if (take) data_q <= mem_rdata_i;
    end

    p_std_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ren_i |=> $stable(rdata_o));
    p_empty_aempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      empty_o |-> aempty_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cptr_q  <= '0;
      gray_q  <= '0;
      under_q <= 1'b0;
    end else begin
      cptr_q <= cptr_nxt;
      gray_q <= cptr_nxt ^ (cptr_nxt >> 1);
      if (ren_i && empty_o) under_q <= 1'b1;
    end
  end

  assign rdata_o = data_q;
  assign under_o = under_q;
  assign gray_o  = gray_q;

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_i && empty_o) |=> $stable(cptr_q));
  p_under_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    under_o |=> under_o);
  p_level_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level <= DEPTH);
endmodule

// File: rtl/dc_fifo.sv
module dc_fifo #(
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 4,
  parameter int                SYNC_STAGES = 2,
  parameter bit                ASYNC       = 1'b1,
  parameter dcf_pkg::rd_mode_e RD_MODE     = dcf_pkg::RD_STD
) (
  input  logic              rst_ni,
  input  logic              wclk_i,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W:0]   afull_thr_i,
  output logic              full_o,
  output logic              afull_o,
  output logic              wover_o,
  input  logic              rclk_i,
  input  logic              ren_i,
  input  logic [ADDR_W:0]   aempty_thr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              runder_o
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int XSTG  = ASYNC ? SYNC_STAGES : 0;

  logic [CNT_W-1:0]  wgray, rgray, wptr_r, rptr_w;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  dcf_wr_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen_i(wen_i), .wdata_i(wdata_i),
    .thr_i(afull_thr_i), .rptr_i(rptr_w), .full_o(full_o), .afull_o(afull_o),
    .over_o(wover_o), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata), .gray_o(wgray)
  );

  dcf_ptr_xing #(.W(CNT_W), .STAGES(XSTG)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wptr_r)
  );

  dcf_ptr_xing #(.W(CNT_W), .STAGES(XSTG)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rptr_w)
  );

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk_i(wclk_i), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(mem_raddr), .rdata_o(mem_rdata)
  );

  dcf_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_MODE(RD_MODE)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .ren_i(ren_i), .thr_i(aempty_thr_i),
    .wptr_i(wptr_r), .mem_rdata_i(mem_rdata), .mem_raddr_o(mem_raddr),
    .rdata_o(rdata_o), .empty_o(empty_o), .aempty_o(aempty_o),
    .under_o(runder_o), .gray_o(rgray)
  );
endmodule

// File: tb/tb_dc_fifo.sv
`timescale 1ns/1ps
module tb_dc_fifo;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AF = 12;
  localparam int AE = 3;

  logic rst_ni = 1'b0;
  logic wclk = 1'b0, rclk = 1'b0;
  always #4 wclk = ~wclk;     // 125 MHz
  always #5.5 rclk = ~rclk;   // unrelated read clock

  // dual-clock, standard read
  logic a_wen = 0, a_ren = 0;
  logic [DW-1:0] a_wdata = '0, a_rdata;
  logic a_full, a_afull, a_over, a_empty, a_aempty, a_under;
  // single-clock, look-ahead read
  logic f_wen = 0, f_ren = 0;
  logic [DW-1:0] f_wdata = '0, f_rdata;
  logic f_full, f_afull, f_over, f_empty, f_aempty, f_under;

  dc_fifo #(.DATA_W(DW), .ADDR_W(AW), .ASYNC(1'b1), .RD_MODE(dcf_pkg::RD_STD)) dut (
    .rst_ni(rst_ni), .wclk_i(wclk), .wen_i(a_wen), .wdata_i(a_wdata),
    .afull_thr_i(5'(AF)), .full_o(a_full), .afull_o(a_afull), .wover_o(a_over),
    .rclk_i(rclk), .ren_i(a_ren), .aempty_thr_i(5'(AE)), .rdata_o(a_rdata),
    .empty_o(a_empty), .aempty_o(a_aempty), .runder_o(a_under)
  );

  dc_fifo #(.DATA_W(DW), .ADDR_W(AW), .ASYNC(1'b0), .RD_MODE(dcf_pkg::RD_FWFT)) dut_fwft (
    .rst_ni(rst_ni), .wclk_i(wclk), .wen_i(f_wen), .wdata_i(f_wdata),
    .afull_thr_i(5'(AF)), .full_o(f_full), .afull_o(f_afull), .wover_o(f_over),
    .rclk_i(wclk), .ren_i(f_ren), .aempty_thr_i(5'(AE)), .rdata_o(f_rdata),
    .empty_o(f_empty), .aempty_o(f_aempty), .runder_o(f_under)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] qa[$];
  logic [DW-1:0] qf[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_full(int n);   return n == DEPTH; endfunction
  function automatic logic exp_afull(int n);  return n >= AF;    endfunction
  function automatic logic exp_aempty(int n); return n <= AE;    endfunction

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic a_flags(int n);
    chk("R5 full", a_full, exp_full(n));
    chk("R6 empty", a_empty, n == 0);
    chk("R7 afull", a_afull, exp_afull(n));
    chk("R8 aempty", a_aempty, exp_aempty(n));
  endtask

  task automatic a_write(logic [DW-1:0] d, bit enq);
    @(negedge wclk); a_wen = 1; a_wdata = d;
    if (enq) qa.push_back(d);
    @(negedge wclk); a_wen = 0;
  endtask

  task automatic a_read_chk();
    logic [DW-1:0] e;
    @(negedge rclk); a_ren = 1;
    @(negedge rclk); a_ren = 0;
    e = qa.pop_front();
    chk("R9 rdata after read edge", a_rdata, e);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge wclk);
    rst_ni = 1;
    repeat (2) @(negedge wclk);

    // R1 reset state
    chk("R1 empty", a_empty, 1); chk("R1 aempty", a_aempty, 1);
    chk("R1 full", a_full, 0);   chk("R1 afull", a_afull, 0);
    chk("R1 over", a_over, 0);   chk("R1 under", a_under, 0);
    chk("R1 fwft empty", f_empty, 1); chk("R1 fwft full", f_full, 0);
    chk("R1 fwft over", f_over, 0);   chk("R1 fwft under", f_under, 0);

    // fill one at a time, flags at each level (R5..R8)
    for (int i = 1; i <= DEPTH; i++) begin
      a_write(8'(i * 13 + 7), 1);
      settle();
      a_flags(i);
    end
    // R3 write while full is dropped
    a_write(8'hEE, 0);
    settle();
    chk("R3 overflow sticky", a_over, 1);
    chk("R3 still full", a_full, 1);
    // drain with data order (R2, R9) and flags
    for (int i = DEPTH - 1; i >= 0; i--) begin
      a_read_chk();
      settle();
      a_flags(i);
    end
    chk("R2 drained queue", qa.size(), 0);
    // R4 read while empty is dropped
    @(negedge rclk); a_ren = 1;
    @(negedge rclk); a_ren = 0;
    settle();
    chk("R4 underflow sticky", a_under, 1);
    chk("R4 still empty", a_empty, 1);
    chk("R3 overflow held", a_over, 1);
    a_write(8'h3C, 1);
    settle();
    a_read_chk();

    // R2 concurrent random traffic on unrelated clocks
    fork
      begin
        int n = 0;
        while (n < 300) begin
          @(negedge wclk);
          if (!a_full && ($urandom % 3 != 0)) begin
            a_wen = 1; a_wdata = 8'($urandom); qa.push_back(a_wdata); n++;
          end else a_wen = 0;
        end
        @(negedge wclk); a_wen = 0;
      end
      begin
        int issued = 0, got = 0;
        bit pend = 0;
        while (got < 300) begin
          @(negedge rclk);
          if (pend) begin
            chk("R2 async order", a_rdata, qa.pop_front());
            got++;
          end
          pend = 0;
          if (issued < 300 && !a_empty && ($urandom % 4 != 0)) begin
            a_ren = 1; pend = 1; issued++;
          end else a_ren = 0;
        end
        a_ren = 0;
      end
    join
    settle();
    a_flags(0);

    // R10 first word visible without a read, one clock after the write
    @(negedge wclk); f_wen = 1; f_wdata = 8'h5A; qf.push_back(8'h5A);
    @(negedge wclk); f_wen = 0;
    chk("R10 not yet loaded", f_empty, 1);
    @(negedge wclk);
    chk("R10 empty low before read", f_empty, 0);
    chk("R10 head on rdata", f_rdata, 8'h5A);
    repeat (3) @(negedge wclk);
    chk("R10 head held", f_rdata, 8'h5A);

    // R11 R12 random single-clock traffic, reads and writes often coincide
    for (int c = 0; c < 1500; c++) begin
      @(negedge wclk);
      if (!f_empty) chk("R11 head", f_rdata, qf[0]);
      chk("R12 full vs count", f_full, exp_full(qf.size()));
      chk("R11 afull counts output reg", f_afull, exp_afull(qf.size()));
      chk("R12 aempty vs count", f_aempty, exp_aempty(qf.size()));
      if (!f_empty && ($urandom % 2 == 0)) begin
        f_ren = 1; void'(qf.pop_front());
      end else f_ren = 0;
      if (!f_full && ($urandom % ((c / 300) % 2 == 0 ? 2 : 3) != 0)) begin
        f_wen = 1; f_wdata = 8'($urandom); qf.push_back(f_wdata);
      end else f_wen = 0;
    end
    @(negedge wclk); f_wen = 0; f_ren = 0;
    while (!f_empty) begin
      chk("R11 drain head", f_rdata, qf[0]);
      void'(qf.pop_front());
      f_ren = 1;
      @(negedge wclk); f_ren = 0;
      @(negedge wclk);
    end
    chk("R2 fwft drained", qf.size(), 0);
    chk("R4 fwft no underflow", f_under, 0);
    chk("R3 fwft no overflow", f_over, 0);

    done = 1;
    report();
  end
endmodule